// File: doc/BRIEF.md
# FEAC Code Word Transmitter

This block sends a far-end alarm and control code word on a serial line. A processor loads a 6-bit code into a code register. It then writes the configuration/status register with the GO bit rising and the transmitter enable set. The block latches the code and builds a 16-bit frame from it. It sends that frame ten times back to back, one bit for each strobe from the framer. When the block is idle, or when the transmitter is disabled, the line carries all ones.

When the last bit of the tenth frame has gone out, the block sets a completion status bit, which clears when the processor reads it. That status pulls the active-low interrupt output down only when two enables are both 1: the source enable bit in the configuration register and a block-level enable input. If the transmitter enable is cleared in the middle of a message, the message is abandoned.

The register port is byte-wide and has a single address bit. Address 0 is the configuration/status register. Address 1 is the code register. Read data is registered.

Top module: `feac_sender`

## Requirements
- R1: After reset, `ser_out` is 1 and `irq_n` is 1. `rdata` is 0. Every configuration bit and the code register are 0.
- R2: The frame is sent in this order: a 0, then code bits 0 to 5 (least significant first), then a 0, then eight 1s.
- R3: An accepted GO sends the frame exactly 10 times with no gap between frames. After that, `ser_out` stays 1.
- R4: A frame bit advances only in a cycle where `bit_strobe` is 1. It appears on `ser_out` one clock later and holds until the next strobe.
- R5: A GO is accepted only when a write to address 0 sets bit 1 to 1 while the stored bit 1 is 0, sets bit 2 to 1 in the same write, and the block is not busy. Any other GO write starts nothing.
- R6: Busy (bit 0 at address 0) reads 1 from the clock after an accepted GO. It clears at the clock where the last bit of the 10th frame appears on `ser_out`.
- R7: The completion status (bit 3 at address 0) is set at the same clock where busy clears after the 10th frame. A read of address 0 clears it. If a read and a completion fall in the same cycle, the completion wins.
- R8: `irq_n` goes low one clock after the status, the source enable (bit 4 at address 0) and `sect_irq_en` are all 1. In every other case, `irq_n` goes high one clock later.
- R9: If the transmitter enable (bit 2) reads 0 while busy, the message is abandoned. Busy clears at the next clock, `ser_out` goes to 1, and no completion status is set.
- R10: A read of address 0 returns {3'b000, source enable, status, transmitter enable, GO, busy} with busy at bit 0. A read of address 1 returns {2'b00, code}. `rdata` updates only on a read.
- R11: The code is latched at the GO. Writes to the code register while busy do not change the message being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register address: 0 config/status, 1 code |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| sect_irq_en | input | 1 | Block-level interrupt enable |
| bit_strobe | input | 1 | Framer bit-enable strobe |
| ser_out | output | 1 | Serial FEAC bit stream |
| irq_n | output | 1 | Active-low completion interrupt |

## Verification
A wrong bit index or a wrong repeat counter shows on `ser_out` at the first strobe that follows. Because the frame is mostly 1s, a shifted code field or a missing 0 marker appears within one frame. An off-by-one repeat count moves the clearing of busy and the setting of status by a whole frame: `rdata` shows it on the next read, and `irq_n` shows it one clock after the status. The bench runs a reference model alongside the design and compares all three outputs on every clock. Divergence is therefore reported in the cycle it first appears, under strobe patterns that are steady, sparse and pseudo-random.

// File: rtl/feac_pkg.sv
package feac_pkg;
  localparam int DATA_W = 8;

  // Bit positions in the configuration/status register
  localparam int CFG_BUSY = 0;
  localparam int CFG_GO   = 1;
  localparam int CFG_EN   = 2;
  localparam int CFG_ST   = 3;
  localparam int CFG_IE   = 4;

  typedef enum logic [0:0] {
    ADDR_CFG  = 1'b0,
    ADDR_CODE = 1'b1
  } reg_addr_e;
endpackage

// File: rtl/feac_regs.sv
module feac_regs
  import feac_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              frame_done,
  output logic [DATA_W-1:0] rdata,
  output logic [CODE_W-1:0] code_q,
  output logic              tx_en,
  output logic              irq_ie,
  output logic              irq_st,
  output logic              go_accept
);
  logic              go_q;
  logic              cfg_wr, code_wr, cfg_rd;
  logic [DATA_W-1:0] cfg_byte, code_byte;

  assign cfg_wr  = wr_en && (addr == ADDR_CFG);
  assign code_wr = wr_en && (addr == ADDR_CODE);
  assign cfg_rd  = rd_en && (addr == ADDR_CFG);

  // A GO counts only on a rising stored GO bit, with the enable in the same write
  assign go_accept = cfg_wr && wdata[CFG_GO] && !go_q && wdata[CFG_EN] && !busy;

  always_comb begin
    cfg_byte           = '0;
    cfg_byte[CFG_BUSY] = busy;
    cfg_byte[CFG_GO]   = go_q;
    cfg_byte[CFG_EN]   = tx_en;
    cfg_byte[CFG_ST]   = irq_st;
    cfg_byte[CFG_IE]   = irq_ie;
    code_byte          = '0;
    code_byte[CODE_W-1:0] = code_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      go_q   <= 1'b0;
      tx_en  <= 1'b0;
      irq_ie <= 1'b0;
      irq_st <= 1'b0;
      code_q <= '0;
      rdata  <= '0;
    end else begin
      if (cfg_wr) begin
        go_q   <= wdata[CFG_GO];
        tx_en  <= wdata[CFG_EN];
        irq_ie <= wdata[CFG_IE];
      end
      if (code_wr) code_q <= wdata[CODE_W-1:0];
      // Completion has priority over the clear-on-read
      if (frame_done)  irq_st <= 1'b1;
      else if (cfg_rd) irq_st <= 1'b0;
      if (rd_en) rdata <= (addr == ADDR_CFG) ? cfg_byte : code_byte;
    end
  end
endmodule

// File: rtl/feac_framer.sv
module feac_framer #(
  parameter int CODE_W  = 6,
  parameter int ONES_W  = 8,
  parameter int REPEATS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              go_accept,
  input  logic              bit_strobe,
  input  logic [CODE_W-1:0] code,
  output logic              busy,
  output logic              frame_done,
  output logic              ser_out
);
  localparam int FRAME_W = CODE_W + ONES_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int REP_W   = (REPEATS > 1) ? $clog2(REPEATS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_W - 1);
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPEATS - 1);

  logic [FRAME_W-1:0] frame_q;
  logic [IDX_W-1:0]   idx_q;
  logic [REP_W-1:0]   rep_q;
  logic               last_bit, last_rep;

  assign last_bit   = (idx_q == IDX_LAST);
  assign last_rep   = (rep_q == REP_LAST);
  assign frame_done = busy && tx_en && bit_strobe && last_bit && last_rep;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      idx_q   <= '0;
      rep_q   <= '0;
      frame_q <= '1;
      ser_out <= 1'b1;
    end else begin
      if (go_accept) begin
        busy    <= 1'b1;
        idx_q   <= '0;
        rep_q   <= '0;
        // Bit 0 goes out first: marker 0, code LSB first, marker 0, ones
        frame_q <= {{ONES_W{1'b1}}, 1'b0, code, 1'b0};
      end else if (busy && !tx_en) begin
        busy <= 1'b0;
      end else if (busy && bit_strobe) begin
        if (last_bit) begin
          idx_q <= '0;
          if (last_rep) busy <= 1'b0;
          else          rep_q <= rep_q + 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end

      if (!tx_en)          ser_out <= 1'b1;
      else if (bit_strobe) ser_out <= busy ? frame_q[idx_q] : 1'b1;
    end
  end
endmodule

// File: rtl/feac_irq.sv
module feac_irq (
  input  logic clk,
  input  logic rst,
  input  logic irq_st,
  input  logic irq_ie,
  input  logic sect_irq_en,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= !(irq_st && irq_ie && sect_irq_en);
  end
endmodule

// File: rtl/feac_sender.sv
module feac_sender
  import feac_pkg::*;
#(
  parameter int CODE_W  = 6,
  parameter int ONES_W  = 8,
  parameter int REPEATS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              sect_irq_en,
  input  logic              bit_strobe,
  output logic              ser_out,
  output logic              irq_n
);
  logic [CODE_W-1:0] code_q;
  logic tx_en, irq_ie, irq_st, go_accept, busy, frame_done;

  feac_regs #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .busy(busy), .frame_done(frame_done), .rdata(rdata),
    .code_q(code_q), .tx_en(tx_en), .irq_ie(irq_ie), .irq_st(irq_st),
    .go_accept(go_accept)
  );

  feac_framer #(.CODE_W(CODE_W), .ONES_W(ONES_W), .REPEATS(REPEATS)) u_framer (
    .clk(clk), .rst(rst), .tx_en(tx_en), .go_accept(go_accept),
    .bit_strobe(bit_strobe), .code(code_q), .busy(busy),
    .frame_done(frame_done), .ser_out(ser_out)
  );

  feac_irq u_irq (
    .clk(clk), .rst(rst), .irq_st(irq_st), .irq_ie(irq_ie),
    .sect_irq_en(sect_irq_en), .irq_n(irq_n)
  );
endmodule

// File: rtl/feac_sender_chk.sv
module feac_sender_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_en,
  input logic       addr,
  input logic [7:0] rdata,
  input logic       sect_irq_en,
  input logic       bit_strobe,
  input logic       ser_out,
  input logic       irq_n,
  input logic       busy,
  input logic       tx_en,
  input logic       irq_st,
  input logic       irq_ie,
  input logic       go_accept,
  input logic       frame_done
);
  assert_idle_ones_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ser_out);

  assert_hold_bit_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && tx_en && !bit_strobe) |=> $stable(ser_out));

  assert_go_busy_R5: assert property (@(posedge clk) disable iff (rst)
    go_accept |=> busy);

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && tx_en && !bit_strobe) |=> busy);

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !addr && !frame_done) |=> !irq_st);

  assert_irq_low_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_st && irq_ie && sect_irq_en) |=> !irq_n);

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !sect_irq_en |=> irq_n);

  assert_abort_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !tx_en) |=> (!busy && ser_out));

  assert_cfg_pad_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !addr) |=> (rdata[7:5] == 3'b000));
endmodule

bind feac_sender feac_sender_chk u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .sect_irq_en(sect_irq_en), .bit_strobe(bit_strobe), .ser_out(ser_out),
  .irq_n(irq_n), .busy(busy), .tx_en(tx_en), .irq_st(irq_st),
  .irq_ie(irq_ie), .go_accept(go_accept), .frame_done(frame_done)
);

// File: tb/tb_feac_sender.sv
module tb_feac_sender;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sect_irq_en = 1'b0, bit_strobe = 1'b0;
  logic       ser_out, irq_n;

  feac_sender dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sect_irq_en(sect_irq_en),
    .bit_strobe(bit_strobe), .ser_out(ser_out), .irq_n(irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    tests = 0, fails = 0, cycles = 0;
  bit    ended = 1'b0;
  string cur_req = "R1";

  // Strobe generator: 0 never, 1 every cycle, 2 one in three, 3 pseudo-random
  int         strobe_mode = 0;
  int         div = 0;
  logic [7:0] lfsr = 8'hA5;
  always @(negedge clk) begin
    div  <= (div == 2) ? 0 : div + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (strobe_mode)
      1:       bit_strobe <= 1'b1;
      2:       bit_strobe <= (div == 0);
      3:       bit_strobe <= lfsr[0];
      default: bit_strobe <= 1'b0;
    endcase
  end

  // Reference model
  bit         q[$];
  logic       m_go, m_en, m_ie, m_st, m_busy, m_ser, m_irqn;
  logic [5:0] m_code;
  logic [7:0] m_rdata;

  always @(posedge clk) begin
    logic acc, done, n_ser, n_busy, n_st;
    if (rst) begin
      m_go = 0; m_en = 0; m_ie = 0; m_st = 0; m_busy = 0;
      m_ser = 1; m_irqn = 1; m_code = '0; m_rdata = '0;
      q.delete();
    end else begin
      acc    = wr_en && !addr && wdata[1] && !m_go && wdata[2] && !m_busy;
      done   = 1'b0;
      n_ser  = m_ser;
      n_busy = m_busy;
      if (acc) begin
        q.delete();
        for (int r = 0; r < 10; r++)
          for (int b = 0; b < 16; b++)
            q.push_back((b == 0 || b == 7) ? 1'b0 : (b <= 6) ? m_code[b-1] : 1'b1);
        n_busy = 1'b1;
      end else if (m_busy && !m_en) begin
        q.delete();
        n_busy = 1'b0;
      end else if (m_busy && bit_strobe) begin
        n_ser = q.pop_front();
        if (q.size() == 0) begin n_busy = 1'b0; done = 1'b1; end
      end
      if (!m_en) n_ser = 1'b1;
      else if (bit_strobe && !m_busy) n_ser = 1'b1;

      n_st = m_st;
      if (rd_en && !addr) n_st = 1'b0;
      if (done) n_st = 1'b1;

      if (rd_en)
        m_rdata = !addr ? {3'b000, m_ie, m_st, m_en, m_go, m_busy} : {2'b00, m_code};
      m_irqn = !(m_st && m_ie && sect_irq_en);
      if (wr_en && !addr) begin m_ie = wdata[4]; m_en = wdata[2]; m_go = wdata[1]; end
      if (wr_en && addr) m_code = wdata[5:0];
      m_st = n_st; m_busy = n_busy; m_ser = n_ser;
    end
  end

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!ended) begin
      tests++;
      if (ser_out !== m_ser) begin
        fails++;
        $display("FAIL %s ser_out actual=%b expected=%b t=%0t", cur_req, ser_out, m_ser, $time);
      end
      tests++;
      if (irq_n !== m_irqn) begin
        fails++;
        $display("FAIL %s irq_n actual=%b expected=%b t=%0t", cur_req, irq_n, m_irqn, $time);
      end
      tests++;
      if (rdata !== m_rdata) begin
        fails++;
        $display("FAIL %s rdata actual=%h expected=%h t=%0t", cur_req, rdata, m_rdata, $time);
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !ended) begin
      fails++;
      $display("FAIL watchdog in %s actual=%0d cycles expected<=%0d", cur_req, cycles, WATCHDOG);
      finish_run();
    end
  end

  // Driver tasks: entered at a negedge, leave at a negedge
  task automatic do_wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic a);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && m_busy; i++) @(negedge clk);
    idle(2);
  endtask

  initial begin
    cur_req = "R1 reset";
    idle(5);
    rst = 1'b0;
    idle(2);
    do_rd(1'b0);
    idle(1);

    cur_req = "R10 register layout";
    do_wr(1'b1, 8'hED);           // upper bits dropped, code 6'h2D
    do_rd(1'b1);
    do_rd(1'b0);
    idle(1);

    cur_req = "R2 R3 R4 R6 frame stream";
    sect_irq_en = 1'b1;
    strobe_mode = 2;
    do_wr(1'b0, 8'h16);           // ie, en, go
    idle(3);
    do_rd(1'b0);                  // busy bit reads 1
    idle(40);

    cur_req = "R11 R5 code latched, GO while busy";
    do_wr(1'b1, 8'h13);
    do_wr(1'b0, 8'h14);
    do_wr(1'b0, 8'h16);           // rising GO while busy: ignored
    wait_idle();

    cur_req = "R7 R8 completion and read clear";
    idle(3);
    do_rd(1'b0);
    idle(3);

    cur_req = "R8 block-level gate";
    sect_irq_en = 1'b0;
    strobe_mode = 1;
    do_wr(1'b0, 8'h14);
    do_wr(1'b0, 8'h16);
    wait_idle();
    idle(3);
    sect_irq_en = 1'b1;
    idle(3);
    do_wr(1'b0, 8'h04);           // source enable off
    idle(3);
    do_wr(1'b0, 8'h14);
    idle(2);
    do_rd(1'b0);
    idle(2);

    cur_req = "R5 GO without enable";
    do_wr(1'b0, 8'h02);
    idle(5);
    do_rd(1'b0);
    do_wr(1'b0, 8'h10);
    idle(2);

    cur_req = "R9 abort on enable clear";
    strobe_mode = 3;
    do_wr(1'b0, 8'h16);
    idle(40);
    do_wr(1'b0, 8'h10);
    idle(5);
    do_rd(1'b0);
    idle(2);

    cur_req = "R2 R3 pseudo-random strobe";
    do_wr(1'b1, 8'h2A);
    do_wr(1'b0, 8'h14);
    do_wr(1'b0, 8'h16);
    wait_idle();
    do_rd(1'b0);
    idle(2);

    cur_req = "R7 completion wins over read";
    strobe_mode = 1;
    do_wr(1'b0, 8'h14);
    do_wr(1'b0, 8'h16);
    for (int i = 0; i < 4000 && q.size() != 1; i++) @(negedge clk);
    do_rd(1'b0);                  // coincides with the final bit
    idle(3);
    do_rd(1'b0);
    idle(3);

    cur_req = "R1 second reset";
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(2);
    finish_run();
  end
endmodule